// File: doc/BRIEF.md
# Weather Alert Sync Framer

This block sits behind a data demodulator that recovers the serial bitstream of a weather alert broadcast, delivered as one bit per strobe at a nominal 520.83 bit/s. The block does no clock division of its own. While the output enable is low it runs in sync search: it hunts for a run of preamble bytes sent least significant bit first, then compares the next four bytes against a start header and an end header. A start header raises an interrupt, sets a status flag and turns on the output enable by itself. An end header raises an interrupt and sets its own flag, but the block stays in search.

While the output enable is high, the block packs every eight received bits into a byte, stores the byte in the host data register and raises the interrupt. The host may also set the output enable directly. This gives a raw mode with no preamble or header check and no guarantee of byte alignment. Only the host clears the output enable, and doing so re-arms the search. A master decoder enable holds the whole block idle and cleared while it is low.

Top module: `wx_sync_framer`

## Requirements
- R1: While `dec_en` is low, the cycle after any clock edge shows `oen`, `irq`, `flag_start`, `flag_end`, `flag_ovr` and `rx_byte` all at zero. Strobes have no effect, and `oen` stays low after `dec_en` returns.
- R2: In sync search the block never writes `rx_byte` and never raises `irq` unless it sees a full header. This includes a preamble of only PRE_MIN-1 bytes followed by a start header.
- R3: At least PRE_MIN consecutive 0xAB bytes (first bit received is bit 0), then the bytes 0x5A 0x43 0x5A 0x43, make `flag_start`, `irq` and `oen` high at the clock edge that samples the strobe carrying the last header bit.
- R4: The same preamble followed by four 0x4E bytes sets `flag_end` and `irq` while `oen` stays low. Search continues, so a later valid start header is still detected.
- R5: A header byte that matches neither header returns the block to preamble search with no flag and no interrupt.
- R6: With `oen` high, every eighth strobe loads `rx_byte` with the assembled byte (first received bit at bit 0) and raises `irq` on the edge that samples that strobe.
- R7: A host pulse on `oen_set` enters raw mode at once. Bytes are counted from the first strobe after the pulse, and a strobe in the same cycle as a host write is dropped.
- R8: `oen` falls only on a host `oen_clr` pulse or on `dec_en` low. A falling `oen` returns the block to search.
- R9: `irq` and the status flags are sticky until a `host_rd` pulse clears them. An event sampled in the same cycle as the read wins.
- R10: An event that arrives while `irq` is pending and unread sets `flag_ovr` and overwrites `rx_byte`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dec_en | input | 1 | Master decoder enable |
| bit_stb | input | 1 | One-cycle strobe marking a recovered bit |
| bit_val | input | 1 | Recovered bit value, valid with the strobe |
| oen_set | input | 1 | Host pulse that sets the output enable |
| oen_clr | input | 1 | Host pulse that clears the output enable |
| host_rd | input | 1 | Host read of the data/status register; clears interrupt and flags |
| rx_byte | output | 8 | Last assembled data byte |
| flag_start | output | 1 | Start header seen |
| flag_end | output | 1 | End header seen |
| flag_ovr | output | 1 | Event arrived before the previous one was read |
| oen | output | 1 | Output enable (data-output mode) |
| irq | output | 1 | Sticky interrupt request |

## Verification
The bench builds the block with PRE_MIN set to 4 instead of 8 and keeps the default header length and preamble byte. The shorter preamble keeps each sync sequence brief, so one run fits a too-short preamble of three bytes, an end header, a corrupted header and a valid start header. It can then go on to data bytes, raw mode, an overrun and a disable. The three-versus-four boundary exercises the same run-counter compare that the default uses at seven versus eight.

// File: rtl/wx_pkg.sv
package wx_pkg;
  localparam int SYM_W = 8;

  typedef enum logic [1:0] {
    EV_NONE  = 2'd0,
    EV_START = 2'd1,
    EV_END   = 2'd2,
    EV_BYTE  = 2'd3
  } ev_t;

  typedef enum logic [1:0] {
    S_SRCH = 2'd0,
    S_HDR  = 2'd1,
    S_DATA = 2'd2
  } st_t;

  localparam logic [SYM_W-1:0] CH_Z = 8'h5A;
  localparam logic [SYM_W-1:0] CH_C = 8'h43;
  localparam logic [SYM_W-1:0] CH_N = 8'h4E;

  // start header alternates Z and C; end header repeats N
  function automatic logic [SYM_W-1:0] start_char(input int unsigned pos);
    return (pos % 2 == 0) ? CH_Z : CH_C;
  endfunction
endpackage

// File: rtl/wx_bit_window.sv
module wx_bit_window #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         stb,
  input  logic         bit_in,
  output logic [W-1:0] win_nxt
);
  logic [W-1:0] win_q;

  // oldest bit drifts toward bit 0, so a byte sent LSB first lands in order
  assign win_nxt = {bit_in, win_q[W-1:1]};

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      win_q <= '0;
    end else if (stb) begin
      win_q <= win_nxt;
    end
  end
endmodule

// File: rtl/wx_sync_fsm.sv
module wx_sync_fsm
  import wx_pkg::*;
#(
  parameter int               PRE_MIN  = 8,
  parameter logic [SYM_W-1:0] PRE_BYTE = 8'hAB,
  parameter int               HDR_LEN  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             stb,
  input  logic [SYM_W-1:0] win_nxt,
  input  logic             host_set,
  input  logic             host_clr,
  output ev_t              ev,
  output logic             data_mode
);
  localparam int CNT_W = $clog2(SYM_W);
  localparam int RUN_W = $clog2(PRE_MIN + 1);
  localparam int IDX_W = (HDR_LEN > 1) ? $clog2(HDR_LEN) : 1;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(SYM_W - 1);
  localparam logic [RUN_W-1:0] RUN_MIN  = RUN_W'(PRE_MIN);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(HDR_LEN - 1);

  st_t             st_q, st_n;
  logic [CNT_W-1:0] bcnt_q, bcnt_n;
  logic [RUN_W-1:0] run_q, run_n;
  logic [IDX_W-1:0] idx_q, idx_n;
  logic             zok_q, zok_n, nok_q, nok_n;
  logic             z_hit, n_hit;

  assign z_hit = (win_nxt == start_char(int'(idx_q)));
  assign n_hit = (win_nxt == CH_N);

  always_comb begin
    st_n   = st_q;
    bcnt_n = bcnt_q;
    run_n  = run_q;
    idx_n  = idx_q;
    zok_n  = zok_q;
    nok_n  = nok_q;
    ev     = EV_NONE;
    if (host_clr) begin
      st_n   = S_SRCH;
      bcnt_n = '0;
      run_n  = '0;
    end else if (host_set) begin
      st_n   = S_DATA;
      bcnt_n = '0;
    end else if (stb) begin
      unique case (st_q)
        S_SRCH: begin
          if (win_nxt == PRE_BYTE) begin
            if (bcnt_q == LAST_BIT && run_q != '0)
              run_n = (run_q >= RUN_MIN) ? RUN_MIN : run_q + 1'b1;
            else
              run_n = RUN_W'(1);
            bcnt_n = '0;
          end else if (bcnt_q == LAST_BIT && run_q >= RUN_MIN) begin
            // first header byte sits right behind the preamble
            zok_n  = (win_nxt == start_char(0));
            nok_n  = n_hit;
            idx_n  = IDX_W'(1);
            bcnt_n = '0;
            run_n  = '0;
            st_n   = (zok_n || nok_n) ? S_HDR : S_SRCH;
          end else begin
            if (bcnt_q == LAST_BIT) run_n = '0;
            bcnt_n = bcnt_q + 1'b1;
          end
        end
        S_HDR: begin
          if (bcnt_q == LAST_BIT) begin
            zok_n  = zok_q && z_hit;
            nok_n  = nok_q && n_hit;
            bcnt_n = '0;
            if (!zok_n && !nok_n) begin
              st_n = S_SRCH;
            end else if (idx_q == IDX_LAST) begin
              if (zok_n) begin
                ev   = EV_START;
                st_n = S_DATA;
              end else begin
                ev   = EV_END;
                st_n = S_SRCH;
              end
            end else begin
              idx_n = idx_q + 1'b1;
            end
          end else begin
            bcnt_n = bcnt_q + 1'b1;
          end
        end
        S_DATA: begin
          if (bcnt_q == LAST_BIT) begin
            ev     = EV_BYTE;
            bcnt_n = '0;
          end else begin
            bcnt_n = bcnt_q + 1'b1;
          end
        end
        default: st_n = S_SRCH;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      st_q   <= S_SRCH;
      bcnt_q <= '0;
      run_q  <= '0;
      idx_q  <= '0;
      zok_q  <= 1'b0;
      nok_q  <= 1'b0;
    end else begin
      st_q   <= st_n;
      bcnt_q <= bcnt_n;
      run_q  <= run_n;
      idx_q  <= idx_n;
      zok_q  <= zok_n;
      nok_q  <= nok_n;
    end
  end

  assign data_mode = (st_q == S_DATA);
endmodule

// File: rtl/wx_host_regs.sv
module wx_host_regs
  import wx_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  ev_t              ev,
  input  logic [SYM_W-1:0] ev_byte,
  input  logic             host_rd,
  output logic [SYM_W-1:0] rx_byte,
  output logic             flag_start,
  output logic             flag_end,
  output logic             flag_ovr,
  output logic             irq
);
  logic pend_unread;
  assign pend_unread = irq && !host_rd;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      rx_byte    <= '0;
      flag_start <= 1'b0;
      flag_end   <= 1'b0;
      flag_ovr   <= 1'b0;
      irq        <= 1'b0;
    end else begin
      if (host_rd) begin
        flag_start <= 1'b0;
        flag_end   <= 1'b0;
        flag_ovr   <= 1'b0;
        irq        <= 1'b0;
      end
      if (ev != EV_NONE) begin
        irq <= 1'b1;
        if (pend_unread) flag_ovr <= 1'b1;
        unique case (ev)
          EV_START: flag_start <= 1'b1;
          EV_END:   flag_end   <= 1'b1;
          EV_BYTE:  rx_byte    <= ev_byte;
          default:  ;
        endcase
      end
    end
  end
endmodule

// File: rtl/wx_sync_framer.sv
module wx_sync_framer
  import wx_pkg::*;
#(
  parameter int               PRE_MIN  = 8,
  parameter logic [SYM_W-1:0] PRE_BYTE = 8'hAB,
  parameter int               HDR_LEN  = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       dec_en,
  input  logic       bit_stb,
  input  logic       bit_val,
  input  logic       oen_set,
  input  logic       oen_clr,
  input  logic       host_rd,
  output logic [7:0] rx_byte,
  output logic       flag_start,
  output logic       flag_end,
  output logic       flag_ovr,
  output logic       oen,
  output logic       irq
);
  logic             stb_eff;
  logic [SYM_W-1:0] win_nxt;
  ev_t              ev;

  // a host write pre-empts a strobe landing in the same cycle
  assign stb_eff = bit_stb && !oen_set && !oen_clr;

  wx_bit_window #(.W(SYM_W)) u_win (
    .clk     (clk),
    .rst     (rst),
    .en      (dec_en),
    .stb     (stb_eff),
    .bit_in  (bit_val),
    .win_nxt (win_nxt)
  );

  wx_sync_fsm #(
    .PRE_MIN  (PRE_MIN),
    .PRE_BYTE (PRE_BYTE),
    .HDR_LEN  (HDR_LEN)
  ) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .en        (dec_en),
    .stb       (stb_eff),
    .win_nxt   (win_nxt),
    .host_set  (oen_set),
    .host_clr  (oen_clr),
    .ev        (ev),
    .data_mode (oen)
  );

  wx_host_regs u_regs (
    .clk        (clk),
    .rst        (rst),
    .en         (dec_en),
    .ev         (ev),
    .ev_byte    (win_nxt),
    .host_rd    (host_rd),
    .rx_byte    (rx_byte),
    .flag_start (flag_start),
    .flag_end   (flag_end),
    .flag_ovr   (flag_ovr),
    .irq        (irq)
  );
endmodule

// File: rtl/wx_framer_chk.sv
module wx_framer_chk (
  input logic       clk,
  input logic       rst,
  input logic       dec_en,
  input logic       oen_clr,
  input logic       host_rd,
  input logic [7:0] rx_byte,
  input logic       flag_start,
  input logic       flag_end,
  input logic       flag_ovr,
  input logic       oen,
  input logic       irq
);
  p_idle_clear_r1: assert property (@(posedge clk) disable iff (rst)
    !dec_en |=> (!oen && !irq && !flag_start && !flag_end && !flag_ovr && rx_byte == 8'h00));

  p_start_sets_oen_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_start) |-> (oen && irq));

  p_end_raises_irq_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_end) |-> irq);

  p_byte_with_irq_r6: assert property (@(posedge clk) disable iff (rst)
    (!$stable(rx_byte) && $past(dec_en)) |-> irq);

  p_oen_fall_by_host_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(oen) |-> ($past(oen_clr) || !$past(dec_en)));

  p_read_clears_ovr_r9: assert property (@(posedge clk) disable iff (rst)
    host_rd |=> !flag_ovr);

  p_ovr_needs_irq_r10: assert property (@(posedge clk) disable iff (rst)
    flag_ovr |-> irq);
endmodule

bind wx_sync_framer wx_framer_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .dec_en     (dec_en),
  .oen_clr    (oen_clr),
  .host_rd    (host_rd),
  .rx_byte    (rx_byte),
  .flag_start (flag_start),
  .flag_end   (flag_end),
  .flag_ovr   (flag_ovr),
  .oen        (oen),
  .irq        (irq)
);

// File: tb/sim_wx_sync_framer.sv
`timescale 1ns/1ps
module sim_wx_sync_framer;
  localparam int PMIN = 4;
  localparam int KIND_START = 1;
  localparam int KIND_END   = 2;
  localparam int KIND_BYTE  = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic dec_en = 1'b0, bit_stb = 1'b0, bit_val = 1'b0;
  logic oen_set = 1'b0, oen_clr = 1'b0;
  logic tb_rd = 1'b0, mon_rd = 1'b0, mon_en = 1'b1;
  logic host_rd;
  logic [7:0] rx_byte;
  logic flag_start, flag_end, flag_ovr, oen, irq;

  int checks = 0, failures = 0;
  int exp_kind[$];
  logic [7:0] exp_byte[$];

  assign host_rd = tb_rd | mon_rd;
  always #2.5 clk = ~clk;

  wx_sync_framer #(.PRE_MIN(PMIN)) u0 (
    .clk(clk), .rst(rst), .dec_en(dec_en), .bit_stb(bit_stb), .bit_val(bit_val),
    .oen_set(oen_set), .oen_clr(oen_clr), .host_rd(host_rd), .rx_byte(rx_byte),
    .flag_start(flag_start), .flag_end(flag_end), .flag_ovr(flag_ovr),
    .oen(oen), .irq(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk); bit_stb = 1'b1; bit_val = b;
    @(negedge clk); bit_stb = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 0; i < 8; i++) send_bit(b[i]);
  endtask

  task automatic send_pre(input int n);
    for (int i = 0; i < n; i++) send_byte(8'hAB);
  endtask

  task automatic expect_ev(input int k, input logic [7:0] b);
    exp_kind.push_back(k);
    exp_byte.push_back(b);
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    if (which == 0) oen_set = 1'b1; else if (which == 1) oen_clr = 1'b1; else tb_rd = 1'b1;
    @(negedge clk);
    oen_set = 1'b0; oen_clr = 1'b0; tb_rd = 1'b0;
    @(negedge clk);
  endtask

  // monitor: pops the expected item whenever an interrupt is pending and reads it
  always @(negedge clk) begin
    mon_rd <= 1'b0;
    if (mon_en && irq && !mon_rd) begin
      if (exp_kind.size() == 0) begin
        checks++; failures++;
        $display("FAIL R2 unexpected event actual=start%0d end%0d byte%0h expected=none",
                 flag_start, flag_end, rx_byte);
      end else begin
        int k;
        logic [7:0] b;
        k = exp_kind.pop_front();
        b = exp_byte.pop_front();
        chk("R3/R4 event kind", flag_start ? KIND_START : (flag_end ? KIND_END : KIND_BYTE), k);
        if (k == KIND_BYTE) chk("R6 data byte", rx_byte, b);
        chk("R10 no overrun", flag_ovr, 0);
      end
      mon_rd <= 1'b1;
    end
  end

  initial begin
    repeat (20000 * 8) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset / disabled state
    chk("R1 irq idle", irq, 0);
    chk("R1 oen idle", oen, 0);
    chk("R1 rx_byte idle", rx_byte, 0);
    send_byte(8'hAB);
    chk("R1 strobes ignored while disabled", irq, 0);
    dec_en = 1'b1;
    @(negedge clk);

    // R2: preamble one byte short, then start header
    send_pre(PMIN - 1);
    send_byte(8'h5A); send_byte(8'h43); send_byte(8'h5A); send_byte(8'h43);
    chk("R2 short preamble no irq", irq, 0);
    chk("R2 short preamble oen low", oen, 0);

    // R4: end header reported, stays in search
    expect_ev(KIND_END, 8'h00);
    send_pre(PMIN);
    send_byte(8'h4E); send_byte(8'h4E); send_byte(8'h4E); send_byte(8'h4E);
    chk("R4 oen stays low after end header", oen, 0);

    // R5: corrupted header
    send_pre(PMIN);
    send_byte(8'h5A); send_byte(8'h43); send_byte(8'h11); send_byte(8'h43);
    chk("R5 mismatch no irq", irq, 0);
    chk("R5 mismatch oen low", oen, 0);

    // R3: valid start header (search continued after R4 end header)
    expect_ev(KIND_START, 8'h00);
    send_pre(PMIN + 1);
    send_byte(8'h5A); send_byte(8'h43); send_byte(8'h5A); send_byte(8'h43);
    chk("R3 oen auto-set", oen, 1);

    // R6: data bytes in data-output mode
    expect_ev(KIND_BYTE, 8'h12); send_byte(8'h12);
    expect_ev(KIND_BYTE, 8'hF0); send_byte(8'hF0);
    expect_ev(KIND_BYTE, 8'hA5); send_byte(8'hA5);
    chk("R6 queue drained", exp_kind.size(), 0);

    // R8: host clear returns to search, no bytes
    pulse(1);
    chk("R8 oen cleared by host", oen, 0);
    send_byte(8'h5A);
    chk("R8 search after clear no irq", irq, 0);

    // R7: raw mode by host set
    pulse(0);
    chk("R7 oen set by host", oen, 1);
    expect_ev(KIND_BYTE, 8'h81); send_byte(8'h81);
    expect_ev(KIND_BYTE, 8'h7E); send_byte(8'h7E);
    chk("R7 raw bytes drained", exp_kind.size(), 0);

    // R10 / R9: overrun and sticky interrupt
    mon_en = 1'b0;
    send_byte(8'h3C);
    repeat (10) @(negedge clk);
    chk("R9 irq sticky", irq, 1);
    chk("R10 no ovr on first", flag_ovr, 0);
    send_byte(8'hC3);
    chk("R10 ovr set", flag_ovr, 1);
    chk("R10 byte overwritten", rx_byte, 8'hC3);
    pulse(2);
    chk("R9 read clears irq", irq, 0);
    chk("R9 read clears ovr", flag_ovr, 0);
    mon_en = 1'b1;

    // R1: disable while in data mode
    @(negedge clk); dec_en = 1'b0;
    @(negedge clk);
    chk("R1 oen cleared by disable", oen, 0);
    chk("R1 rx_byte cleared by disable", rx_byte, 0);
    send_byte(8'h55);
    chk("R1 disabled strobes ignored", irq, 0);
    dec_en = 1'b1;
    @(negedge clk);
    chk("R1 oen low after re-enable", oen, 0);

    repeat (10) @(negedge clk);
    chk("scoreboard empty", exp_kind.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule